// File: doc/BRIEF.md
# Burst Address and Write Command Front-End

This block is the synchronous command front-end of a burst static RAM. On every rising clock edge it samples two active-low address strobes, a processor strobe and a controller strobe. It also samples an active-low burst-advance input, three chip enables (one active-high and two active-low), a global write input, a byte write input with per-lane enables, a burst-order select and a sleep input. From these it forms the array address, a registered read or write command with a per-lane write mask, and a read-valid flag and a deselect flag for the output stage.

A started burst loads the full address. Later beats keep the upper bits and take the two low bits from a 2-bit counter. The counter output is either added to the loaded low bits (linear order) or combined with them by XOR (interleaved order). It wraps to the starting address after four beats. Each output is registered, so every result appears one clock after the edge that sampled the inputs.

Top module: `burst_cmd_front`

## Requirements
- R1: While reset is asserted, all outputs are zero: arr_addr, cmd_vld, cmd_wr, wr_mask, rd_vld and desel.
- R2: A strobe sampled with all enables active (ce1_n=0, ce2=1, ce3_n=0) issues a command at the sampled address on the next cycle, with cmd_vld=1 and desel=0.
- R3: The processor strobe is ignored when ce1_n=1. A strobe that is recognised while any enable is inactive gives desel=1 and cmd_vld=0 on the next cycle, and it ends the burst.
- R4: A burst started by the processor strobe is always a read, whatever the write inputs are: cmd_wr=0, rd_vld=1, wr_mask=0. The processor strobe takes priority over the controller strobe.
- R5: Write mask bit i covers lane i. gw_n=0 gives the mask 4'b1111. Otherwise bw_n=0 gives the mask ~lane_n. A mask of zero means a read, with cmd_wr=0 and rd_vld=1. A controller strobe writes when the mask is non-zero.
- R6: With burst_ilv=0 sampled at the burst start (linear order), each beat with adv_n=0 sets arr_addr[1:0] to start+k modulo 4, where k is the beat count. Bits above bit 1 keep the loaded value.
- R7: With burst_ilv=1 sampled at the burst start (interleaved order), each beat with adv_n=0 sets arr_addr[1:0] to start XOR k.
- R8: The fourth advancing beat returns arr_addr to the starting address.
- R9: A cycle with no strobe and adv_n=1 during a burst reissues the command at the same address.
- R10: While sleep=1, no command is issued, cmd_vld, rd_vld and desel are 0, and advance pulses do not step the counter. After sleep the burst resumes from where it stopped.
- R11: A continuing beat takes its read or write type from the write inputs in that cycle. Reads and writes step the counter alike.
- R12: With no strobe and no burst in progress, no command is issued and desel=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | AW | External address |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bw_n | input | 1 | Byte write, active low |
| lane_n | input | LANES | Per-lane write enables, active low |
| burst_ilv | input | 1 | 1 selects interleaved order, 0 selects linear order |
| sleep | input | 1 | Low-power request, active high |
| arr_addr | output | AW | Array address of the current command |
| cmd_vld | output | 1 | Command valid |
| cmd_wr | output | 1 | 1 for a write command |
| wr_mask | output | LANES | Lanes written, zero on reads |
| rd_vld | output | 1 | Read command issued |
| desel | output | 1 | Device deselected this cycle |

## Verification
Several rules are checked on every cycle:
- the quiet outputs during sleep;
- reads from processor-strobe bursts;
- deselect on a disabled strobe;
- the held address on a suspended beat;
- the +1 step in linear order;
- the all-lanes mask on a global write.

Other behaviour needs the bench's scenarios to show it. These are the whole interleaved sequence, the wrap after four beats, each of the sixteen lane masks, and the counter resuming unchanged after sleep. The bench sweeps every start value in both orders to cover them.

// File: rtl/burst_cmd_front.sv
module burst_cmd_front #(
  parameter int AW    = 18,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr_in,
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             adv_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             gw_n,
  input  logic             bw_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             burst_ilv,
  input  logic             sleep,
  output logic [AW-1:0]    arr_addr,
  output logic             cmd_vld,
  output logic             cmd_wr,
  output logic [LANES-1:0] wr_mask,
  output logic             rd_vld,
  output logic             desel
);
  localparam int CW = 2;

  logic [AW-1:0] base_q;
  logic [CW-1:0] cnt_q;
  logic          lin_q;
  logic          act_q;

  logic             p_go, c_go, strobe, en_ok, wr_in, start_wr;
  logic [LANES-1:0] mask_in;
  logic [CW-1:0]    cnt_nx, lo_nx;

  assign p_go     = !adsp_n && !ce1_n;
  assign c_go     = !adsc_n;
  assign strobe   = p_go || c_go;
  assign en_ok    = !ce1_n && ce2 && !ce3_n;
  assign mask_in  = !gw_n ? {LANES{1'b1}} : (!bw_n ? ~lane_n : {LANES{1'b0}});
  assign wr_in    = |mask_in;
  assign start_wr = !p_go && wr_in;
  assign cnt_nx   = adv_n ? cnt_q : cnt_q + 1'b1;
  assign lo_nx    = lin_q ? base_q[CW-1:0] + cnt_nx : base_q[CW-1:0] ^ cnt_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      cnt_q    <= '0;
      lin_q    <= 1'b0;
      act_q    <= 1'b0;
      arr_addr <= '0;
      cmd_vld  <= 1'b0;
      cmd_wr   <= 1'b0;
      wr_mask  <= '0;
      rd_vld   <= 1'b0;
      desel    <= 1'b0;
    end else if (sleep) begin
      cmd_vld <= 1'b0;
      rd_vld  <= 1'b0;
      desel   <= 1'b0;
      cmd_wr  <= 1'b0;
      wr_mask <= '0;
    end else if (strobe && en_ok) begin
      base_q   <= addr_in;
      cnt_q    <= '0;
      lin_q    <= !burst_ilv;
      act_q    <= 1'b1;
      arr_addr <= addr_in;
      cmd_vld  <= 1'b1;
      cmd_wr   <= start_wr;
      wr_mask  <= start_wr ? mask_in : '0;
      rd_vld   <= !start_wr;
      desel    <= 1'b0;
    end else if (strobe) begin
      act_q   <= 1'b0;
      cmd_vld <= 1'b0;
      cmd_wr  <= 1'b0;
      wr_mask <= '0;
      rd_vld  <= 1'b0;
      desel   <= 1'b1;
    end else if (act_q) begin
      cnt_q    <= cnt_nx;
      arr_addr <= {base_q[AW-1:CW], lo_nx};
      cmd_vld  <= 1'b1;
      cmd_wr   <= wr_in;
      wr_mask  <= mask_in;
      rd_vld   <= !wr_in;
      desel    <= 1'b0;
    end else begin
      cmd_vld <= 1'b0;
      cmd_wr  <= 1'b0;
      wr_mask <= '0;
      rd_vld  <= 1'b0;
      desel   <= 1'b1;
    end
  end

  p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!cmd_vld && !rd_vld && !desel));

  p_proc_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && p_go && en_ok) |=> (cmd_vld && !cmd_wr && rd_vld && wr_mask == '0));

  p_off_desel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && strobe && !en_ok) |=> (desel && !cmd_vld));

  p_hold_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !strobe && act_q && adv_n) |=> $stable(arr_addr));

  p_lin_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !strobe && act_q && !adv_n && lin_q) |=>
      (arr_addr[CW-1:0] == $past(arr_addr[CW-1:0]) + 1'b1));

  p_gw_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && c_go && !p_go && en_ok && !gw_n) |=> (cmd_wr && wr_mask == {LANES{1'b1}}));
endmodule

// File: tb/burst_cmd_front_bench.sv
module burst_cmd_front_bench;
  localparam int AW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic adsp_n = 1, adsc_n = 1, adv_n = 1, ce1_n = 0, ce2 = 1, ce3_n = 0;
  logic gw_n = 1, bw_n = 1, burst_ilv = 1, sleep = 0;
  logic [3:0] lane_n = 4'hF;
  logic [AW-1:0] arr_addr;
  logic cmd_vld, cmd_wr, rd_vld, desel;
  logic [3:0] wr_mask;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  burst_cmd_front #(.AW(AW), .LANES(4)) u_burst_cmd_front (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n), .bw_n(bw_n),
    .lane_n(lane_n), .burst_ilv(burst_ilv), .sleep(sleep), .arr_addr(arr_addr),
    .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .wr_mask(wr_mask), .rd_vld(rd_vld), .desel(desel));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle_in();
    adsp_n = 1; adsc_n = 1; adv_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
    gw_n = 1; bw_n = 1; lane_n = 4'hF; sleep = 0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R1 outputs", {arr_addr, cmd_vld, cmd_wr, wr_mask, rd_vld, desel}, 0);
    rst_n = 1;
    tick();
    chk("R12 idle desel", {cmd_vld, desel}, 2'b01);

    for (int ilv = 0; ilv < 2; ilv++) begin
      for (int s = 0; s < 4; s++) begin
        idle_in(); burst_ilv = ilv[0]; addr_in = 8'hA4 | s[7:0]; adsc_n = 0;
        tick();
        chk("R2 start addr", arr_addr, 8'hA4 | s);
        chk("R2 start read", {cmd_vld, rd_vld, cmd_wr, desel}, 4'b1100);
        adsc_n = 1; adv_n = 0; burst_ilv = ~ilv[0];
        for (int k = 1; k <= 4; k++) begin
          tick();
          if (k == 4) chk("R8 wrap", arr_addr, 8'hA4 | s);
          else if (ilv == 0) chk("R6 linear", arr_addr, 8'hA4 | ((s + k) % 4));
          else chk("R7 interleaved", arr_addr, 8'hA4 | (s ^ k));
        end
      end
    end

    idle_in(); burst_ilv = 0; addr_in = 8'h31; adsc_n = 0; tick();
    adsc_n = 1; adv_n = 0; tick();
    chk("R6 step", arr_addr, 8'h32);
    adv_n = 1; tick();
    chk("R9 suspend", arr_addr, 8'h32);
    tick();
    chk("R9 suspend again", {arr_addr, cmd_vld}, {8'h32, 1'b1});

    idle_in(); adsc_n = 0; ce2 = 0; tick();
    chk("R3 disabled strobe", {cmd_vld, desel}, 2'b01);
    idle_in(); adsp_n = 0; ce1_n = 1; ce3_n = 1; tick();
    chk("R3 blocked processor strobe", {cmd_vld, desel}, 2'b01);

    idle_in(); adsp_n = 0; adsc_n = 0; gw_n = 0; addr_in = 8'h55; tick();
    chk("R4 processor read", {arr_addr, cmd_vld, cmd_wr, rd_vld, wr_mask}, {8'h55, 3'b101, 4'h0});

    for (int m = 0; m < 16; m++) begin
      idle_in(); adsc_n = 0; bw_n = 0; lane_n = ~m[3:0]; addr_in = 8'h10; tick();
      chk("R5 lane mask", wr_mask, m);
      chk("R5 write flag", {cmd_wr, rd_vld}, (m != 0) ? 2'b10 : 2'b01);
    end
    idle_in(); adsc_n = 0; gw_n = 0; bw_n = 0; lane_n = 4'hE; tick();
    chk("R5 global write", {cmd_wr, wr_mask}, 5'h1F);

    idle_in(); burst_ilv = 0; addr_in = 8'h40; adsc_n = 0; tick();
    adsc_n = 1; adv_n = 0; gw_n = 0; tick();
    chk("R11 write beat", {arr_addr, cmd_wr, wr_mask}, {8'h41, 1'b1, 4'hF});
    gw_n = 1; tick();
    chk("R11 dummy read beat", {arr_addr, cmd_wr, rd_vld}, {8'h42, 2'b01});

    idle_in(); burst_ilv = 0; addr_in = 8'h80; adsc_n = 0; tick();
    adsc_n = 1; sleep = 1; adv_n = 0; tick();
    chk("R10 sleep quiet", {cmd_vld, rd_vld, desel}, 0);
    tick();
    chk("R10 sleep quiet 2", {cmd_vld, desel}, 0);
    sleep = 0; tick();
    chk("R10 resume", {arr_addr, cmd_vld}, {8'h81, 1'b1});

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule